// File: doc/BRIEF.md
# Instruction Fetch Control Sequencer

This block is the control sequencer for a small 16-bit processor datapath. All registers in that datapath share one system bus. Tri-state gates place a value on the bus, and load enables capture it into a register. The sequencer emits the gate, load, program-counter source select and memory strobes, so that one instruction word moves through the datapath:

1. The program counter goes into the memory address register.
2. The memory is read.
3. The returned word lands in the memory data register.
4. The word is passed over the bus into the instruction register, and the program counter advances.

After fetch, the sequencer steps through the decode, address evaluation, operand fetch, execute and store-result phases. Each of these is one placeholder cycle. It then starts the next fetch. A 3-bit phase output reports which phase of the instruction cycle is active.

All strobes are registered. A synchronous active-high reset leaves every strobe low and arms the sequencer, so that the first clock edge after reset is released enters fetch step one. Memory timing is variable. The memory read step repeats until the memory raises its ready input.

Top module: `fetch_sequencer`

## Requirements
- R1: While reset is high, and in the cycle it is sampled, every strobe output is 0 and the phase output is 0. The first clock edge that samples reset low presents fetch step one.
- R2: Fetch step one drives only pc_gate_o and mar_ld_o high. The phase output is 0.
- R3: Fetch step two drives only mem_rw_o (1 = read) and mem_en_o high. It repeats on every edge that samples mem_rdy low.
- R4: The edge that samples mem_rdy high during fetch step two moves the sequencer to fetch step three. Step three drives mdr_ld_o and mem_rw_o high, and all other strobes low.
- R5: Fetch step four drives mdr_gate_o, ir_ld_o and pc_ld_o high, with pc_sel_o = 2'b00 (the increment source). All other strobes are low. pc_sel_o is 2'b00 in every cycle.
- R6: Fetch step five drives every strobe low, with the phase output still 0.
- R7: After fetch step five, the phase output takes the values 1 (decode), 2 (address evaluation), 3 (operand fetch), 4 (execute) and 5 (store result), each for exactly one cycle with all strobes low. Fetch step one then follows.
- R8: pc_gate_o and mdr_gate_o are never high in the same cycle, so the bus has at most one driver.
- R9: mem_rdy has no effect in any step other than fetch step two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdy | input | 1 | Memory reports that read data is valid |
| pc_gate_o | output | 1 | Drive the program counter onto the bus |
| mdr_gate_o | output | 1 | Drive the memory data register onto the bus |
| mar_ld_o | output | 1 | Load the memory address register from the bus |
| mdr_ld_o | output | 1 | Load the memory data register from memory |
| ir_ld_o | output | 1 | Load the instruction register from the bus |
| pc_ld_o | output | 1 | Load the program counter |
| pc_sel_o | output | 2 | Program counter source select, 00 = increment |
| mem_rw_o | output | 1 | Memory direction, 1 = read |
| mem_en_o | output | 1 | Memory access enable |
| phase_o | output | 3 | Current instruction-cycle phase code |

## Verification
On every cycle, the assertions check four things:
- the single-driver rule on the bus;
- that the memory read step does not end before ready is seen;
- the step order MAR load → memory enable, and MDR load → IR load → idle;
- that the phase code only ever moves forward by one, wrapping from store back to fetch.

The exact set of strobes in each step can only be shown by the bench scenarios. The same holds for these behaviours:
- how many cycles the read step lasts for a given memory delay;
- that ready pulses outside the read step change nothing;
- that a reset in the middle of a cycle restarts cleanly at fetch step one.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam int PHASE_W = 3;
    localparam int SEL_W   = 2;
    localparam int STEP_W  = 4;

    typedef enum logic [STEP_W-1:0] {
        ST_START = 4'd0,
        ST_F1    = 4'd1,
        ST_F2    = 4'd2,
        ST_F3    = 4'd3,
        ST_F4    = 4'd4,
        ST_F5    = 4'd5,
        ST_DEC   = 4'd6,
        ST_AEV   = 4'd7,
        ST_OPF   = 4'd8,
        ST_EXE   = 4'd9,
        ST_STO   = 4'd10
    } step_e;

    typedef enum logic [PHASE_W-1:0] {
        PH_FETCH   = 3'd0,
        PH_DECODE  = 3'd1,
        PH_ADDR    = 3'd2,
        PH_OPERAND = 3'd3,
        PH_EXEC    = 3'd4,
        PH_STORE   = 3'd5
    } phase_e;

    localparam logic [SEL_W-1:0] PC_SRC_INC = 2'b00;

    typedef struct packed {
        logic             pc_gate;
        logic             mdr_gate;
        logic             mar_ld;
        logic             mdr_ld;
        logic             ir_ld;
        logic             pc_ld;
        logic [SEL_W-1:0] pc_sel;
        logic             mem_rw;
        logic             mem_en;
    } strobe_t;

    function automatic phase_e phase_of(step_e s);
        case (s)
            ST_DEC:  return PH_DECODE;
            ST_AEV:  return PH_ADDR;
            ST_OPF:  return PH_OPERAND;
            ST_EXE:  return PH_EXEC;
            ST_STO:  return PH_STORE;
            default: return PH_FETCH;
        endcase
    endfunction

endpackage

// File: rtl/fseq_next.sv
module fseq_next
    import fseq_pkg::*;
(
    input  step_e cur,
    input  logic  mem_rdy,
    output step_e nxt
);
    always_comb begin
        case (cur)
            ST_START: nxt = ST_F1;
            ST_F1:    nxt = ST_F2;
            ST_F2:    nxt = mem_rdy ? ST_F3 : ST_F2;
            ST_F3:    nxt = ST_F4;
            ST_F4:    nxt = ST_F5;
            ST_F5:    nxt = ST_DEC;
            ST_DEC:   nxt = ST_AEV;
            ST_AEV:   nxt = ST_OPF;
            ST_OPF:   nxt = ST_EXE;
            ST_EXE:   nxt = ST_STO;
            ST_STO:   nxt = ST_F1;
            default:  nxt = ST_F1;
        endcase
    end
endmodule

// File: rtl/fseq_decode.sv
module fseq_decode
    import fseq_pkg::*;
(
    input  step_e   step,
    output strobe_t strb,
    output phase_e  phase
);
    always_comb begin
        strb        = '0;
        strb.pc_sel = PC_SRC_INC;
        case (step)
            ST_F1: begin
                strb.pc_gate = 1'b1;
                strb.mar_ld  = 1'b1;
            end
            ST_F2: begin
                strb.mem_rw = 1'b1;
                strb.mem_en = 1'b1;
            end
            ST_F3: begin
                strb.mem_rw = 1'b1;
                strb.mdr_ld = 1'b1;
            end
            ST_F4: begin
                strb.mdr_gate = 1'b1;
                strb.ir_ld    = 1'b1;
                strb.pc_ld    = 1'b1;
                strb.pc_sel   = PC_SRC_INC;
            end
            default: ;
        endcase
        phase = phase_of(step);
    end
endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
    import fseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               mem_rdy,
    output logic               pc_gate_o,
    output logic               mdr_gate_o,
    output logic               mar_ld_o,
    output logic               mdr_ld_o,
    output logic               ir_ld_o,
    output logic               pc_ld_o,
    output logic [SEL_W-1:0]   pc_sel_o,
    output logic               mem_rw_o,
    output logic               mem_en_o,
    output logic [PHASE_W-1:0] phase_o
);
    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(PH_STORE);

    step_e   cur_q, nxt;
    strobe_t strb_d, strb_q;
    phase_e  phase_d, phase_q;

    fseq_next u_next (
        .cur     (cur_q),
        .mem_rdy (mem_rdy),
        .nxt     (nxt)
    );

    fseq_decode u_dec (
        .step  (nxt),
        .strb  (strb_d),
        .phase (phase_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= ST_START;
            strb_q  <= '0;
            phase_q <= PH_FETCH;
        end else begin
            cur_q   <= nxt;
            strb_q  <= strb_d;
            phase_q <= phase_d;
        end
    end

    assign pc_gate_o  = strb_q.pc_gate;
    assign mdr_gate_o = strb_q.mdr_gate;
    assign mar_ld_o   = strb_q.mar_ld;
    assign mdr_ld_o   = strb_q.mdr_ld;
    assign ir_ld_o    = strb_q.ir_ld;
    assign pc_ld_o    = strb_q.pc_ld;
    assign pc_sel_o   = strb_q.pc_sel;
    assign mem_rw_o   = strb_q.mem_rw;
    assign mem_en_o   = strb_q.mem_en;
    assign phase_o    = phase_q;

    // R8: the shared bus never sees two drivers
    assert_single_driver_R8: assert property (@(posedge clk) disable iff (rst)
        !(pc_gate_o && mdr_gate_o));

    // R2/R3: an address load is followed by the memory access
    assert_mar_then_read_R3: assert property (@(posedge clk) disable iff (rst)
        mar_ld_o |=> (mem_en_o && mem_rw_o));

    // R3: the read step is held while memory is not ready
    assert_hold_read_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_en_o && !mem_rdy) |=> mem_en_o);

    // R4: data capture only after ready was seen during the read
    assert_capture_after_ready_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mdr_ld_o) |-> $past(mem_en_o && mem_rdy));

    // R5: capture is followed by the instruction load
    assert_capture_then_ir_R5: assert property (@(posedge clk) disable iff (rst)
        mdr_ld_o |=> (ir_ld_o && pc_ld_o));

    // R6: the instruction load is followed by a fully idle fetch step
    assert_idle_after_ir_R6: assert property (@(posedge clk) disable iff (rst)
        ir_ld_o |=> (!pc_gate_o && !mdr_gate_o && !mar_ld_o && !mdr_ld_o &&
                     !ir_ld_o && !pc_ld_o && !mem_en_o && phase_o == '0));

    // R7: the phase code only advances by one and wraps after store
    assert_phase_order_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_o != $past(phase_o)) |->
        (phase_o == (($past(phase_o) == LAST_PHASE) ? '0 : $past(phase_o) + 1'b1)));

endmodule

// File: tb/sim_fetch_sequencer.sv
module sim_fetch_sequencer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mem_rdy = 1'b0;
    logic       pc_gate, mdr_gate, mar_ld, mdr_ld, ir_ld, pc_ld, mem_rw, mem_en;
    logic [1:0] pc_sel;
    logic [2:0] phase;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    logic noise = 1'b0;

    logic [12:0] exp_q[$];
    string       tag_q[$];
    int          wait_q[$];
    int          f2cnt = 0;
    int          cur_wait = 0;

    always #5 clk = ~clk;

    fetch_sequencer u0 (
        .clk(clk), .rst(rst), .mem_rdy(mem_rdy),
        .pc_gate_o(pc_gate), .mdr_gate_o(mdr_gate), .mar_ld_o(mar_ld),
        .mdr_ld_o(mdr_ld), .ir_ld_o(ir_ld), .pc_ld_o(pc_ld),
        .pc_sel_o(pc_sel), .mem_rw_o(mem_rw), .mem_en_o(mem_en),
        .phase_o(phase)
    );

    // layout: {phase, pc_gate, mdr_gate, mar_ld, mdr_ld, ir_ld, pc_ld, pc_sel, mem_rw, mem_en}
    function automatic logic [12:0] observed();
        return {phase, pc_gate, mdr_gate, mar_ld, mdr_ld, ir_ld, pc_ld, pc_sel, mem_rw, mem_en};
    endfunction

    // step 0 = reset state, 1..5 fetch steps, 6..10 later phases
    function automatic logic [12:0] expect_of(int step);
        case (step)
            1:  return {3'd0, 6'b101000, 2'b00, 2'b00};  // R2
            2:  return {3'd0, 6'b000000, 2'b00, 2'b11};  // R3
            3:  return {3'd0, 6'b000100, 2'b00, 2'b10};  // R4
            4:  return {3'd0, 6'b010011, 2'b00, 2'b00};  // R5
            6:  return {3'd1, 10'b0};                   // R7
            7:  return {3'd2, 10'b0};
            8:  return {3'd3, 10'b0};
            9:  return {3'd4, 10'b0};
            10: return {3'd5, 10'b0};
            default: return 13'b0;                       // R1, R6
        endcase
    endfunction

    task automatic check(string req, logic [12:0] act, logic [12:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // driver: push one instruction cycle of expectations
    task automatic push_instr(int w, bit first, bit noisy);
        exp_q.push_back(expect_of(1)); tag_q.push_back(first ? "R1" : (noisy ? "R9" : "R2"));
        for (int i = 0; i <= w; i++) begin
            exp_q.push_back(expect_of(2)); tag_q.push_back("R3");
        end
        exp_q.push_back(expect_of(3)); tag_q.push_back("R4");
        exp_q.push_back(expect_of(4)); tag_q.push_back(noisy ? "R9" : "R5");
        exp_q.push_back(expect_of(5)); tag_q.push_back("R6");
        for (int s = 6; s <= 10; s++) begin
            exp_q.push_back(expect_of(s)); tag_q.push_back(noisy ? "R9" : "R7");
        end
        wait_q.push_back(w);
    endtask

    // memory model: ready after the programmed number of extra read cycles
    always @(negedge clk) begin
        if (mem_en === 1'b1) begin
            f2cnt++;
            if (f2cnt == 1) cur_wait = (wait_q.size() > 0) ? wait_q.pop_front() : 0;
            mem_rdy = (f2cnt == cur_wait + 1);
        end else begin
            f2cnt = 0;
            mem_rdy = noise;
        end
    end

    // monitor: compare each cycle against the scoreboard
    always @(negedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            logic [12:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, observed(), e);
            check("R8", {12'b0, pc_gate & mdr_gate}, 13'b0);
        end
    end

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", observed(), 13'b0);
        push_instr(0, 1'b1, 1'b0);
        push_instr(2, 1'b0, 1'b0);
        push_instr(5, 1'b0, 1'b0);
        #1 rst = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
        noise = 1'b1;
        push_instr(1, 1'b0, 1'b1);
        push_instr(0, 1'b0, 1'b1);
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        #1 rst = 1'b1;
        @(negedge clk);
        check("R1", observed(), 13'b0);
        @(negedge clk);
        check("R1", observed(), 13'b0);
        wait_q.delete();
        push_instr(3, 1'b1, 1'b1);
        #1 rst = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        finish_up();
    end

endmodule